// File: doc/BRIEF.md
# High-Side Switch Diagnostic Controller

This block is the digital control and diagnostic core of a two-channel smart high-side power switch. Each channel takes a logic command and a set of comparator flags from the analog front end: load current below the open-load limit, output voltage above the off-state limit, junction over the shutdown temperature, junction at or below the output-restart temperature, and junction at or below the status-release temperature. From these it drives the enable of its power stage and an open-drain status line. The status line is modelled as a pull-low enable and a high-impedance enable.

The status line reports a different fault depending on whether the command is high or low, and each fault has its own qualification delay. Delays are counted in ticks of an external 1 µs strobe and set by parameters at elaboration time. A timer restarts from zero whenever its qualifying condition drops, so short glitches never reach the status line. Thermal shutdown restarts the output on its own once the junction cools. Supply undervoltage, with separate set and clear comparator levels to form a hysteresis, and a status-disable input are shared by both channels.

Top module: `hsd_diag_ctrl`

## Requirements
- R1: After synchronous reset every gate enable is 0 and every status line is released (pull 0, high-impedance 1).
- R2: With no fault flag asserted, a channel's gate enable equals its command in the same cycle and its status stays released for both command levels.
- R3: A high over-temperature flag forces that channel's gate off in the same cycle; the gate stays off after the flag drops until the restart-temperature flag is seen, after which the gate follows the command again.
- R4: The status is pulled low once the over-temperature flag has been held for OT_US ticks and is released when the status-release-temperature flag is high and the over-temperature flag is low; a hot pulse shorter than OT_US ticks never pulls the status.
- R5: With the command high and the gate on, a low-current flag held for OL_ON_US ticks pulls the status low; if the current flag drops while the command is still high, the status is released one cycle later.
- R6: After an on-state open-load report, a falling command keeps the status pulled for POL_US further ticks and then releases it.
- R7: With the command low, an output-high flag held for STK_US ticks pulls the status low; the same flag with the command high never pulls the status; the report clears one cycle after the flag drops or the command rises.
- R8: Fault timers advance only in cycles where tick is 1, and a timer whose condition drops for even one cycle starts again from zero.
- R9: The undervoltage-set flag forces all gates off and all status lines to high-impedance at once; this state persists after the set flag drops until the undervoltage-clear flag is seen.
- R10: While the status-disable input is 1 every status line is high-impedance in the same cycle, and gate enables are unaffected.
- R11: A fault on one channel has no effect on the other channel's gate or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1 µs strobe, one cycle wide |
| uv_low | input | 1 | Supply below the shutdown level |
| uv_clear | input | 1 | Supply above shutdown level plus hysteresis |
| stat_dis | input | 1 | Forces all status lines to high-impedance |
| cmd | input | NCH | Per-channel on command |
| ol_low | input | NCH | Load current below open-load limit |
| vout_hi | input | NCH | Output voltage above off-state limit |
| t_hot | input | NCH | Junction above shutdown temperature |
| t_cool_out | input | NCH | Junction at or below output-restart temperature |
| t_cool_stat | input | NCH | Junction at or below status-release temperature |
| gate_en | output | NCH | Power stage enable |
| stat_pull | output | NCH | Status line driven low |
| stat_hiz | output | NCH | Status line released |

## Verification
The hardest state to reach is the open-load hold after the command falls: the status must already be low from an on-state report, which itself needs the current flag held for the full on-state delay with the gate on, before the falling command starts the second timer. The bench builds this in one scenario and samples just before and just after both delays expire. Timer restart and tick gating are reached by holding the off-state output-high condition for longer than its delay with the tick stopped, and by breaking the condition for a single cycle just short of expiry.

// File: rtl/hsd_diag_pkg.sv
package hsd_diag_pkg;

    // Per-channel comparator view presented to the channel core
    typedef struct packed {
        logic cmd;
        logic ol_low;
        logic vout_hi;
        logic t_hot;
        logic t_cool_out;
        logic t_cool_stat;
    } hsd_sense_t;

    // Per-channel drive towards the pins
    typedef struct packed {
        logic gate;
        logic pull;
        logic hiz;
    } hsd_drive_t;

    function automatic int tmr_width(input int dly);
        return (dly < 1) ? 1 : $clog2(dly + 1);
    endfunction

endpackage

// File: rtl/hsd_delay_filter.sv
module hsd_delay_filter
    import hsd_diag_pkg::*;
#(
    parameter int DLY = 20
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic cond,
    output logic done
);
    localparam int W = tmr_width(DLY);
    localparam logic [W-1:0] LIM = W'(DLY);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!cond)
            cnt <= '0;
        else if (tick && cnt != LIM)
            cnt <= cnt + 1'b1;
    end

    assign done = cond && (cnt == LIM);

    AST_TMR_RESTART: assert property (@(posedge clk) disable iff (rst)
        !cond |=> (cnt == '0)); // R8
    AST_TMR_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cond && !tick) |=> $stable(cnt)); // R8

endmodule

// File: rtl/hsd_channel.sv
module hsd_channel
    import hsd_diag_pkg::*;
#(
    parameter int OT_US    = 20,
    parameter int OL_ON_US = 200,
    parameter int POL_US   = 750,
    parameter int STK_US   = 180
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  hsd_sense_t s,
    input  logic       uv_act,
    input  logic       stat_dis,
    output hsd_drive_t drv
);
    logic tsd_q, ot_q, ol_q, stk_q;
    logic ot_done, olon_done, pol_done, stk_done;
    logic gate;

    assign gate = s.cmd && !s.t_hot && !tsd_q && !uv_act;

    hsd_delay_filter #(.DLY(OT_US)) u_ot (
        .clk(clk), .rst(rst), .tick(tick), .cond(s.t_hot), .done(ot_done));
    hsd_delay_filter #(.DLY(OL_ON_US)) u_olon (
        .clk(clk), .rst(rst), .tick(tick),
        .cond(s.cmd && s.ol_low && gate), .done(olon_done));
    hsd_delay_filter #(.DLY(POL_US)) u_pol (
        .clk(clk), .rst(rst), .tick(tick),
        .cond(!s.cmd && ol_q), .done(pol_done));
    hsd_delay_filter #(.DLY(STK_US)) u_stk (
        .clk(clk), .rst(rst), .tick(tick),
        .cond(!s.cmd && s.vout_hi), .done(stk_done));

    always_ff @(posedge clk) begin
        if (rst) begin
            tsd_q <= 1'b0;
            ot_q  <= 1'b0;
            ol_q  <= 1'b0;
            stk_q <= 1'b0;
        end else begin
            if (s.t_hot)           tsd_q <= 1'b1;
            else if (s.t_cool_out) tsd_q <= 1'b0;

            if (ot_done)                          ot_q <= 1'b1;
            else if (s.t_cool_stat && !s.t_hot)   ot_q <= 1'b0;

            if (olon_done)                        ol_q <= 1'b1;
            else if (s.cmd && !s.ol_low)          ol_q <= 1'b0;
            else if (pol_done)                    ol_q <= 1'b0;

            if (stk_done)                         stk_q <= 1'b1;
            else if (s.cmd || !s.vout_hi)         stk_q <= 1'b0;
        end
    end

    always_comb begin
        drv.gate = gate;
        drv.pull = !stat_dis && !uv_act && (ot_q || ol_q || stk_q);
        drv.hiz  = !drv.pull;
    end

    AST_HOT_GATE_OFF: assert property (@(posedge clk) disable iff (rst)
        s.t_hot |-> !drv.gate); // R3
    AST_TSD_RESTART: assert property (@(posedge clk) disable iff (rst)
        $fell(tsd_q) |-> $past(s.t_cool_out)); // R3
    AST_OL_SET_CMD_HIGH: assert property (@(posedge clk) disable iff (rst)
        $rose(ol_q) |-> $past(s.cmd)); // R5
    AST_STK_SET_CMD_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(stk_q) |-> !$past(s.cmd)); // R7

endmodule

// File: rtl/hsd_diag_ctrl.sv
module hsd_diag_ctrl
    import hsd_diag_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int OT_US    = 20,
    parameter int OL_ON_US = 200,
    parameter int POL_US   = 750,
    parameter int STK_US   = 180
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           tick,
    input  logic           uv_low,
    input  logic           uv_clear,
    input  logic           stat_dis,
    input  logic [NCH-1:0] cmd,
    input  logic [NCH-1:0] ol_low,
    input  logic [NCH-1:0] vout_hi,
    input  logic [NCH-1:0] t_hot,
    input  logic [NCH-1:0] t_cool_out,
    input  logic [NCH-1:0] t_cool_stat,
    output logic [NCH-1:0] gate_en,
    output logic [NCH-1:0] stat_pull,
    output logic [NCH-1:0] stat_hiz
);
    logic uv_q, uv_act;

    always_ff @(posedge clk) begin
        if (rst)           uv_q <= 1'b0;
        else if (uv_low)   uv_q <= 1'b1;
        else if (uv_clear) uv_q <= 1'b0;
    end

    assign uv_act = uv_q || uv_low;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hsd_sense_t sense;
        hsd_drive_t drv;

        always_comb begin
            sense.cmd         = cmd[c];
            sense.ol_low      = ol_low[c];
            sense.vout_hi     = vout_hi[c];
            sense.t_hot       = t_hot[c];
            sense.t_cool_out  = t_cool_out[c];
            sense.t_cool_stat = t_cool_stat[c];
        end

        hsd_channel #(
            .OT_US(OT_US), .OL_ON_US(OL_ON_US),
            .POL_US(POL_US), .STK_US(STK_US)
        ) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .s(sense),
            .uv_act(uv_act), .stat_dis(stat_dis), .drv(drv));

        assign gate_en[c]   = drv.gate;
        assign stat_pull[c] = drv.pull;
        assign stat_hiz[c]  = drv.hiz;
    end

    AST_UV_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        uv_q |-> (gate_en == '0)); // R9
    AST_UV_STATUS_REL: assert property (@(posedge clk) disable iff (rst)
        uv_q |-> (stat_pull == '0)); // R9
    AST_DIS_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stat_dis |-> (stat_pull == '0)); // R10

endmodule

// File: tb/sim_hsd_diag_ctrl.sv
`timescale 1ns/1ps
module sim_hsd_diag_ctrl;
    localparam int NCH = 2;
    localparam int OT  = 20;
    localparam int OLON = 200;
    localparam int POL = 750;
    localparam int STK = 180;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, uv_low = 1'b0, uv_clear = 1'b0, stat_dis = 1'b0;
    logic [NCH-1:0] cmd = '0, ol_low = '0, vout_hi = '0, t_hot = '0;
    logic [NCH-1:0] t_cool_out = '1, t_cool_stat = '1;
    logic [NCH-1:0] gate_en, stat_pull, stat_hiz;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hsd_diag_ctrl #(.NCH(NCH), .OT_US(OT), .OL_ON_US(OLON), .POL_US(POL),
                    .STK_US(STK)) u0 (
        .clk(clk), .rst(rst), .tick(tick), .uv_low(uv_low), .uv_clear(uv_clear),
        .stat_dis(stat_dis), .cmd(cmd), .ol_low(ol_low), .vout_hi(vout_hi),
        .t_hot(t_hot), .t_cool_out(t_cool_out), .t_cool_stat(t_cool_stat),
        .gate_en(gate_en), .stat_pull(stat_pull), .stat_hiz(stat_hiz));

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle();
        cmd = '0; ol_low = '0; vout_hi = '0; t_hot = '0;
        t_cool_out = '1; t_cool_stat = '1; uv_low = 0; uv_clear = 0;
        stat_dis = 0; tick = 1;
        wait_cyc(3);
    endtask

    task automatic t_reset();
        chk("R1 gate after reset", int'(gate_en), 0);
        chk("R1 pull after reset", int'(stat_pull), 0);
        chk("R1 hiz after reset", int'(stat_hiz), 3);
    endtask

    task automatic t_normal();
        cmd = 2'b01; wait_cyc(1);
        chk("R2 gate follows cmd 01", int'(gate_en), 1);
        chk("R2 status released on", int'(stat_pull), 0);
        cmd = 2'b10; wait_cyc(1);
        chk("R2 gate follows cmd 10", int'(gate_en), 2);
        cmd = 2'b00; wait_cyc(1);
        chk("R2 status released off", int'(stat_hiz), 3);
        idle();
    endtask

    task automatic t_thermal();
        cmd = 2'b11; wait_cyc(1);
        t_hot = 2'b01; t_cool_out = 2'b10; t_cool_stat = 2'b10;
        #1 chk("R3 gate off same cycle", int'(gate_en[0]), 0);
        wait_cyc(OT - 1);
        chk("R4 status before OT delay", int'(stat_pull[0]), 0);
        wait_cyc(2);
        chk("R4 status after OT delay", int'(stat_pull[0]), 1);
        chk("R11 other channel unaffected", int'({stat_pull[1], gate_en[1]}), 1);
        t_hot = 2'b00; t_cool_stat = 2'b11; wait_cyc(2);
        chk("R4 status released at cool", int'(stat_pull[0]), 0);
        chk("R3 gate stays off until restart", int'(gate_en[0]), 0);
        t_cool_out = 2'b11; wait_cyc(2);
        chk("R3 gate restarts", int'(gate_en[0]), 1);
        // short hot pulse: latches gate off but no status
        t_hot = 2'b01; t_cool_out = 2'b10; t_cool_stat = 2'b10; wait_cyc(OT - 5);
        t_hot = 2'b00; wait_cyc(OT + 5);
        chk("R4 short pulse no status", int'(stat_pull[0]), 0);
        chk("R3 short pulse gate still off", int'(gate_en[0]), 0);
        idle();
    endtask

    task automatic t_openload();
        cmd = 2'b01; ol_low = 2'b01; wait_cyc(OLON - 1);
        chk("R5 before on-state delay", int'(stat_pull[0]), 0);
        wait_cyc(2);
        chk("R5 after on-state delay", int'(stat_pull[0]), 1);
        ol_low = 2'b00; wait_cyc(2);
        chk("R5 cleared when current returns", int'(stat_pull[0]), 0);
        ol_low = 2'b01; wait_cyc(OLON + 2);
        chk("R5 reported again", int'(stat_pull[0]), 1);
        cmd = 2'b00; wait_cyc(POL - 1);
        chk("R6 held before off delay", int'(stat_pull[0]), 1);
        wait_cyc(2);
        chk("R6 released after off delay", int'(stat_pull[0]), 0);
        idle();
    endtask

    task automatic t_stuck();
        cmd = 2'b01; vout_hi = 2'b01; wait_cyc(STK + 20);
        chk("R7 no report while cmd high", int'(stat_pull[0]), 0);
        cmd = 2'b00; wait_cyc(STK - 1);
        chk("R7 before stuck delay", int'(stat_pull[0]), 0);
        wait_cyc(2);
        chk("R7 after stuck delay", int'(stat_pull[0]), 1);
        chk("R11 other channel released", int'(stat_pull[1]), 0);
        vout_hi = 2'b00; wait_cyc(2);
        chk("R7 clears when output drops", int'(stat_pull[0]), 0);
        idle();
    endtask

    task automatic t_timers();
        tick = 0; vout_hi = 2'b10; wait_cyc(2 * STK);
        chk("R8 no progress without tick", int'(stat_pull[1]), 0);
        tick = 1; wait_cyc(STK + 2);
        chk("R8 progress with tick", int'(stat_pull[1]), 1);
        vout_hi = 2'b00; wait_cyc(2);
        vout_hi = 2'b10; wait_cyc(STK - 5);
        vout_hi = 2'b00; wait_cyc(1);
        vout_hi = 2'b10; wait_cyc(STK - 3);
        chk("R8 restart after one-cycle drop", int'(stat_pull[1]), 0);
        wait_cyc(5);
        chk("R8 full delay after restart", int'(stat_pull[1]), 1);
        idle();
    endtask

    task automatic t_uv_dis();
        vout_hi = 2'b01; wait_cyc(STK + 2);
        chk("R10 fault visible", int'(stat_pull[0]), 1);
        stat_dis = 1; cmd = 2'b10;
        #1 chk("R10 status hiz when disabled", int'(stat_hiz), 3);
        chk("R10 gate unaffected by disable", int'(gate_en), 2);
        wait_cyc(1);
        stat_dis = 0; wait_cyc(1);
        chk("R10 fault back after enable", int'(stat_pull[0]), 1);
        uv_low = 1;
        #1 chk("R9 gates off at once", int'(gate_en), 0);
        chk("R9 status hiz at once", int'(stat_hiz), 3);
        wait_cyc(1);
        uv_low = 0; wait_cyc(3);
        chk("R9 gates stay off until clear", int'(gate_en), 0);
        chk("R9 status stays hiz until clear", int'(stat_pull), 0);
        uv_clear = 1; wait_cyc(1); uv_clear = 0; wait_cyc(1);
        chk("R9 gates recover", int'(gate_en), 2);
        chk("R9 status recovers", int'(stat_pull[0]), 1);
        idle();
    endtask

    initial begin
        wait_cyc(3);
        rst = 0; tick = 1;
        wait_cyc(1);
        t_reset();
        t_normal();
        t_thermal();
        t_openload();
        t_stuck();
        t_timers();
        t_uv_dis();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule